// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Drive Mode

This block is one bank of general-purpose pins, up to eight wide, behind a byte-wide register port. Four registers sit at consecutive offsets from a bank base address. The first sets the pin direction. The second holds the output level. The third shows the synchronized pin levels. The fourth chooses, pin by pin, between open-drain and push-pull drive. On the pad side each pin has an output value, an output enable and an input sample.

Software usually writes the output level first and then turns the pin into an output. For that reason the output latch keeps its value no matter what the direction bit is. In open-drain mode a pin output only ever pulls low: its enable is asserted only while its output bit is 0, and otherwise the pad is released. In push-pull mode an output pin drives the latch value all the time.

The register port is plain control, with no back-pressure. A write takes effect at the clock edge where `reg_wr` is high. A read is captured at the edge where `reg_rd` is high, and its result stays on `reg_rdata` until the next read.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset the direction, output-latch and drive-mode registers are all 0, every pad enable is low, and reads of all four offsets return 0 while the pads are low.
- R2: Offset 0 is direction: bit value 1 makes that pin an output, and 0 makes it an input. A write is read back unchanged (within the pin count).
- R3: A pin whose direction bit is 0 never asserts its pad enable, whatever its latch and mode bits hold.
- R4: Offset 3 bit value 1 selects push-pull. An output pin in push-pull asserts its enable and drives its latch bit on the pad output.
- R5: Offset 3 bit value 0 selects open-drain. An output pin in open-drain asserts its enable only while its latch bit is 0, and its pad output is then 0. With a latch bit of 1 the pad is released.
- R6: Offset 2 returns the pad inputs through two flip-flop stages. A pad change shows in reads issued two or more cycles later, and reads issued earlier return the previous level. Writes to offset 2 have no effect.
- R7: Offset 1 is the output latch. It keeps a value written while the pin is an input, and that value drives the pad as soon as the direction bit is set.
- R8: Register bits at or above the pin count read as 0 and ignore writes.
- R9: The bank responds only to addresses whose upper bits match the base, which must be 4-aligned. Writes elsewhere change nothing, and reads elsewhere return 0.
- R10: Read data appears on `reg_rdata` after the edge that samples `reg_rd`, and it holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address (base plus offset 0..3) |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Registered read data |
| pad_in | input | PIN_COUNT | Raw pin levels from the pads |
| pad_out | output | PIN_COUNT | Pad output value |
| pad_oe | output | PIN_COUNT | Pad output enable |

## Verification
The bench builds the bank with six pins at base 0xE0, not with the default eight at 0xF0. The narrower bank brings the two unused top bits of every register into reach, so the write-masking and read-as-zero rules are exercised. The non-default base makes the address compare work against other upper bits, and addresses just past the bank (0xE4) and at the next bank down (0xD0) check that the decode does not alias. Random writes across all modes are compared against a model of the pad enable and pad value, and directed steps time the two-stage input path to the cycle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // Register offsets inside a bank; the order is what software decodes.
  typedef enum logic [1:0] {
    OFS_DIR  = 2'd0,
    OFS_DOUT = 2'd1,
    OFS_DIN  = 2'd2,
    OFS_MODE = 2'd3
  } gb_ofs_e;

  localparam int OFS_W = 2;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_raw,
  output logic [WIDTH-1:0] pin_sync
);
  logic [WIDTH-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= pin_raw;
      stage2_q <= stage1_q;
    end
  end

  assign pin_sync = stage2_q;

  // Cycles since reset, saturating at 2, so the check never looks before reset.
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
  end

  a_r6_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (pin_sync == $past(pin_raw, 2)));
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int PIN_COUNT = 8
) (
  input  logic [PIN_COUNT-1:0] dir_q,
  input  logic [PIN_COUNT-1:0] dout_q,
  input  logic [PIN_COUNT-1:0] mode_q,
  output logic [PIN_COUNT-1:0] pad_out,
  output logic [PIN_COUNT-1:0] pad_oe
);
  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    // mode 1: push-pull drives the latch; mode 0: open-drain only pulls low.
    assign pad_oe[i]  = dir_q[i] & (mode_q[i] | ~dout_q[i]);
    assign pad_out[i] = mode_q[i] & dout_q[i];
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int PIN_COUNT = 8,
  parameter int ADDR_W    = 8,
  parameter int REG_W     = 8,
  parameter int BASE      = 'hF0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [REG_W-1:0]     wdata,
  input  logic [PIN_COUNT-1:0] pin_sync,
  output logic [PIN_COUNT-1:0] dir_q,
  output logic [PIN_COUNT-1:0] dout_q,
  output logic [PIN_COUNT-1:0] mode_q,
  output logic [REG_W-1:0]     rdata
);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);

  logic                 hit;
  gb_ofs_e              ofs;
  logic [PIN_COUNT-1:0] wbits;
  logic [PIN_COUNT-1:0] rsel;

  assign hit   = (addr[ADDR_W-1:OFS_W] == BASE_V[ADDR_W-1:OFS_W]);
  assign ofs   = gb_ofs_e'(addr[OFS_W-1:0]);
  assign wbits = wdata[PIN_COUNT-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
      mode_q <= '0;
    end else if (wr && hit) begin
      case (ofs)
        OFS_DIR:  dir_q  <= wbits;
        OFS_DOUT: dout_q <= wbits;
        OFS_MODE: mode_q <= wbits;
        default:  ;
      endcase
    end
  end

  always_comb begin
    rsel = '0;
    if (hit) begin
      case (ofs)
        OFS_DIR:  rsel = dir_q;
        OFS_DOUT: rsel = dout_q;
        OFS_DIN:  rsel = pin_sync;
        OFS_MODE: rsel = mode_q;
        default:  rsel = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= REG_W'(rsel);
  end

  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit && ofs == OFS_DIR) |=> (dir_q == $past(wbits)));

  a_r9_miss_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !hit) |=> ($stable(dir_q) && $stable(dout_q) && $stable(mode_q)));

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int PIN_COUNT = 8,
  parameter int ADDR_W    = 8,
  parameter int REG_W     = 8,
  parameter int BASE      = 'hF0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic [PIN_COUNT-1:0] pad_in,
  output logic [PIN_COUNT-1:0] pad_out,
  output logic [PIN_COUNT-1:0] pad_oe
);
  logic [PIN_COUNT-1:0] pin_sync, dir_q, dout_q, mode_q;

  gpio_in_sync #(.WIDTH(PIN_COUNT)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_raw(pad_in), .pin_sync(pin_sync)
  );

  gpio_bank_regs #(
    .PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W), .REG_W(REG_W), .BASE(BASE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .pin_sync(pin_sync), .dir_q(dir_q), .dout_q(dout_q),
    .mode_q(mode_q), .rdata(reg_rdata)
  );

  gpio_pad_drive #(.PIN_COUNT(PIN_COUNT)) u_drive (
    .dir_q(dir_q), .dout_q(dout_q), .mode_q(mode_q),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  a_r3_input_released: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~dir_q) == '0);

  a_r5_od_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~mode_q & pad_out) == '0);

  a_r4_pp_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & dir_q & mode_q) == (dir_q & mode_q));
endmodule

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;
  localparam int PINS = 6;
  localparam int BASE = 'hE0;
  localparam logic [PINS-1:0] MASK = '1;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
  logic [PINS-1:0] pad_in = '0, pad_out, pad_oe;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [PINS-1:0] m_dir = '0, m_dat = '0, m_mode = '0;

  always #10 clk = ~clk;

  gpio_bank_ctrl #(.PIN_COUNT(PINS), .ADDR_W(8), .REG_W(8), .BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic logic [PINS-1:0] f_oe(logic [PINS-1:0] d, logic [PINS-1:0] v, logic [PINS-1:0] m);
    return d & (m | ~v);
  endfunction
  function automatic logic [PINS-1:0] f_out(logic [PINS-1:0] v, logic [PINS-1:0] m);
    return m & v;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Callers stand at a negedge; tasks return at a negedge.
  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (a[7:2] == 6'(BASE >> 2)) begin
      case (a[1:0])
        2'd0: m_dir  = d[PINS-1:0];
        2'd1: m_dat  = d[PINS-1:0];
        2'd3: m_mode = d[PINS-1:0];
        default: ;
      endcase
    end
  endtask

  task automatic rd_reg(logic [7:0] a, output logic [7:0] v);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    v = reg_rdata;
  endtask

  task automatic chk_pads(string req);
    chk(req, 8'(pad_oe), 8'(f_oe(m_dir, m_dat, m_mode)));
    chk(req, 8'(pad_out & pad_oe), 8'(f_out(m_dat, m_mode) & f_oe(m_dir, m_dat, m_mode)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, held;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int o = 0; o < 4; o++) begin
      rd_reg(8'(BASE + o), v);
      chk("R1 reset read", v, 8'h00);
    end
    chk("R1 reset oe", 8'(pad_oe), 8'h00);

    // R7 latch held while input, then drives once direction set
    wr_reg(8'(BASE + 1), 8'h2A);
    chk("R7 no drive while input", 8'(pad_oe), 8'h00);
    rd_reg(8'(BASE + 1), v);
    chk("R7 latch readback", v, 8'h2A);
    wr_reg(8'(BASE + 3), 8'h3F);
    chk("R3 input ignores mode", 8'(pad_oe), 8'h00);
    wr_reg(8'(BASE + 0), 8'h3F);
    chk("R4 push-pull oe", 8'(pad_oe), 8'h3F);
    chk("R7 pad value", 8'(pad_out), 8'h2A);

    // R5 open-drain
    wr_reg(8'(BASE + 3), 8'h00);
    chk("R5 od oe", 8'(pad_oe), 8'h15);
    chk("R5 od out low", 8'(pad_out & pad_oe), 8'h00);

    // R8 upper bits masked
    wr_reg(8'(BASE + 0), 8'hFF);
    rd_reg(8'(BASE + 0), v);
    chk("R8 dir upper bits", v, 8'h3F);
    rd_reg(8'(BASE + 3), v);
    chk("R2 mode readback", v, 8'h00);

    // R9 outside the bank
    wr_reg(8'hE4, 8'h00);
    wr_reg(8'hD0, 8'h00);
    wr_reg(8'hD1, 8'h00);
    rd_reg(8'hE4, v);
    chk("R9 miss read", v, 8'h00);
    rd_reg(8'(BASE + 0), v);
    chk("R9 dir unchanged", v, 8'h3F);
    rd_reg(8'(BASE + 1), v);
    chk("R9 data unchanged", v, 8'h2A);

    // R6 two-stage input timing
    pad_in = 6'h15;
    rd_reg(8'(BASE + 2), v);
    chk("R6 read at change old", v, 8'h00);
    rd_reg(8'(BASE + 2), v);
    chk("R6 read one later old", v, 8'h00);
    rd_reg(8'(BASE + 2), v);
    chk("R6 read two later new", v, 8'h15);
    wr_reg(8'(BASE + 2), 8'h00);
    rd_reg(8'(BASE + 2), v);
    chk("R6 write ignored", v, 8'h15);

    // R10 hold between reads
    held = reg_rdata;
    wr_reg(8'(BASE + 0), 8'h01);
    pad_in = 6'h2A;
    repeat (4) @(negedge clk);
    chk("R10 rdata hold", reg_rdata, held);

    // Random register traffic against the model (R2 R3 R4 R5 R8 R9)
    for (int i = 0; i < 300; i++) begin
      logic [7:0] a, d;
      a = ($urandom % 4 == 0) ? 8'($urandom) : 8'(BASE + ($urandom % 4));
      d = 8'($urandom);
      wr_reg(a, d);
      chk_pads("R3 R4 R5 random pads");
      begin
        int o;
        o = $urandom % 4;
        rd_reg(8'(BASE + o), v);
        case (o)
          0: chk("R2 R8 random dir", v, 8'(m_dir));
          1: chk("R7 R8 random data", v, 8'(m_dat));
          2: chk("R6 random input", v, 8'(pad_in));
          default: chk("R8 random mode", v, 8'(m_mode));
        endcase
      end
      if (i % 50 == 49) begin
        pad_in = PINS'($urandom) & MASK;
        repeat (3) @(negedge clk);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule